// File: doc/BRIEF.md
# Latched Fault Diagnosis Controller

This block sits between the analog protection comparators of an H-bridge motor driver and the serial status path. It samples digital comparator flags on the system clock and qualifies each one with its own timing rule. High-side overcurrent must persist for a delay before it counts. Low-side overcurrent is only honoured inside a blanking window that opens at the first chopper current-limit event. Open load is integrated over the time the bridge is switched on. Temperature and supply faults are taken as they arrive.

Every qualified fault is latched into an 8-bit diagnosis word. The block also drives a single request that turns all output switches off. Overcurrent and overtemperature shutdowns hold the bridge off until a status-clear strobe or a reset. Supply faults release the bridge as soon as the supply recovers, while their diagnosis bit stays latched. The open-load timer pauses while the PWM input is low, so a chopped drive accumulates only its on-time.

Top module: `fault_diag_ctrl`

## Requirements
- R1: After reset, and after a cycle with `stat_clr` high in which no fault input is active, `status` reads 8'h40 (only bit 6 set) and `out_off` is 0. An active-low `rst_n` clears everything at any time.
- R2: `status[0]` is the OR of the fault bits 7, 5, 4, 3, 2 and 1. Bit 6 is a constant 1 and does not contribute to bit 0.
- R3: `hs_oc` high on `HS_DLY_CYC` consecutive clock edges sets `status[4]` after the last of those edges. A single edge with `hs_oc` low restarts the count.
- R4: While `status[4]` or `status[5]` is set, `out_off` is 1. Both bits stay set, regardless of the comparator inputs, until a clear or a reset.
- R5: The first `chop_evt` after reset or a clear opens a window covering the next `BLANK_CYC` edges. `ls_oc` sampled inside that window sets `status[5]`. `ls_oc` outside the window is ignored, and later `chop_evt` pulses do not reopen the window until the next clear.
- R6: The open-load timer advances on edges where `pwm` and `ol_low` are both high, and `status[3]` is set on the `OL_FILT_CYC`-th such edge. An edge with `pwm` high and `ol_low` low returns the count to zero. Edges with `pwm` low hold the count. Open load alone does not raise `out_off`.
- R7: `status[2:1]` holds the highest `temp_code` seen since the last clear: 00 normal, 01 prewarning, 10 warning, 11 shutdown.
- R8: While the latched temperature code is 11, `out_off` is 1.
- R9: When `uv` is high, or `ov` and `ov_en` are both high, on an edge, `status[7]` is set and `out_off` is 1 after that edge. `out_off` returns to 0 one edge after the supply condition goes away, and `status[7]` stays set.
- R10: With `ov_en` low, `ov` has no effect on `status` or `out_off`.
- R11: A clear strobe empties every latch and timer and re-arms the blanking window. A fault input still active at the next edge latches again on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all timers count its edges |
| rst_n | input | 1 | Active-low reset, clears all state |
| hs_oc | input | 1 | High-side current above its shutdown threshold |
| ls_oc | input | 1 | Low-side current above its shutdown threshold |
| ol_low | input | 1 | Low-side current below the open-load reference |
| temp_code | input | 2 | Live temperature level, 00 to 11 |
| uv | input | 1 | Supply below the undervoltage threshold |
| ov | input | 1 | Supply above the overvoltage threshold |
| ov_en | input | 1 | Enables the overvoltage check |
| pwm | input | 1 | Bridge on-phase indicator |
| chop_evt | input | 1 | Chopper current limit reached this cycle |
| stat_clr | input | 1 | Strobe that clears the diagnosis latches |
| status | output | 8 | Latched diagnosis word |
| out_off | output | 1 | Request to switch all output transistors off |

## Verification
Every result in this block is due right after the edge that samples the qualifying input. A latched bit appears after that edge. The delayed faults appear after the HS_DLY_CYC-th or OL_FILT_CYC-th qualifying edge, and the blanking window covers exactly the BLANK_CYC edges after the chopper event. The bench drives inputs and samples outputs 2 ns after a rising edge. Each check therefore sees the state produced by the edge just passed. The boundary tests count edges to sit one edge short of and exactly on each timer limit, and on the last edge inside the blanking window.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

    localparam int unsigned TEMP_W = 2;

    typedef logic [TEMP_W-1:0] temp_t;

    localparam temp_t TEMP_SHUTDOWN = '1;

    // latched fault flags kept in the top level
    typedef struct packed {
        logic hs_flt;
        logic ls_flt;
        logic ol_flt;
        logic sup_flt;
        logic sup_live;
    } fdc_lat_t;

    function automatic temp_t temp_max(input temp_t a, input temp_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fdc_persist_timer.sv
module fdc_persist_timer #(
    parameter int unsigned LIMIT = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic hold,
    output logic reached
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        reached = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (hold) begin
            s_d.cnt = s_q.cnt;
        end else if (run) begin
            if (s_q.cnt >= TOP) begin
                reached = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end else begin
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/fdc_blank_window.sv
module fdc_blank_window #(
    parameter int unsigned BLANK = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic chop_evt,
    output logic active
);
    localparam int unsigned CW = (BLANK < 2) ? 1 : $clog2(BLANK + 1);

    typedef struct packed {
        logic          armed;
        logic [CW-1:0] cnt;
    } win_t;

    win_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        active = (s_q.cnt != '0);
        if (clr) begin
            s_d.armed = 1'b1;
            s_d.cnt   = '0;
        end else begin
            if (active) s_d.cnt = s_q.cnt - CW'(1);
            if (s_q.armed && chop_evt) begin
                s_d.armed = 1'b0;
                s_d.cnt   = CW'(BLANK);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.armed <= 1'b1;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/fdc_temp_hold.sv
module fdc_temp_hold
    import fdc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clr,
    input  temp_t code_in,
    output temp_t code_q
);
    temp_t code_d;

    always_comb begin
        if (clr) code_d = '0;
        else     code_d = temp_max(code_q, code_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

endmodule

// File: rtl/fault_diag_ctrl.sv
module fault_diag_ctrl
    import fdc_pkg::*;
#(
    parameter int unsigned HS_DLY_CYC  = 25,
    parameter int unsigned BLANK_CYC   = 10,
    parameter int unsigned OL_FILT_CYC = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hs_oc,
    input  logic       ls_oc,
    input  logic       ol_low,
    input  logic [1:0] temp_code,
    input  logic       uv,
    input  logic       ov,
    input  logic       ov_en,
    input  logic       pwm,
    input  logic       chop_evt,
    input  logic       stat_clr,
    output logic [7:0] status,
    output logic       out_off
);
    logic     hs_reached;
    logic     ol_reached;
    logic     blank_active;
    logic     sup_now;
    temp_t    temp_q;
    fdc_lat_t l_d, l_q;

    // high-side overcurrent persistence filter
    fdc_persist_timer #(.LIMIT(HS_DLY_CYC)) u_hs_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .run     (hs_oc),
        .hold    (1'b0),
        .reached (hs_reached)
    );

    // open-load filter: pauses while the bridge is off
    fdc_persist_timer #(.LIMIT(OL_FILT_CYC)) u_ol_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .run     (ol_low),
        .hold    (~pwm),
        .reached (ol_reached)
    );

    fdc_blank_window #(.BLANK(BLANK_CYC)) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (stat_clr),
        .chop_evt (chop_evt),
        .active   (blank_active)
    );

    fdc_temp_hold u_temp (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .code_in (temp_code),
        .code_q  (temp_q)
    );

    assign sup_now = uv | (ov & ov_en);

    always_comb begin
        l_d          = l_q;
        l_d.sup_live = sup_now;
        if (stat_clr) begin
            l_d.hs_flt  = 1'b0;
            l_d.ls_flt  = 1'b0;
            l_d.ol_flt  = 1'b0;
            l_d.sup_flt = 1'b0;
        end else begin
            l_d.hs_flt  = l_q.hs_flt  | hs_reached;
            l_d.ls_flt  = l_q.ls_flt  | (blank_active & ls_oc);
            l_d.ol_flt  = l_q.ol_flt  | ol_reached;
            l_d.sup_flt = l_q.sup_flt | sup_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    always_comb begin
        status[7]   = l_q.sup_flt;
        status[6]   = 1'b1;
        status[5]   = l_q.ls_flt;
        status[4]   = l_q.hs_flt;
        status[3]   = l_q.ol_flt;
        status[2:1] = temp_q;
        status[0]   = l_q.sup_flt | l_q.ls_flt | l_q.hs_flt | l_q.ol_flt | (|temp_q);
        out_off     = l_q.hs_flt | l_q.ls_flt | (temp_q == TEMP_SHUTDOWN) | l_q.sup_live;
    end

endmodule

// File: rtl/fdc_chk.sv
module fdc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hs_oc,
    input logic       ls_oc,
    input logic       ol_low,
    input logic       pwm,
    input logic       uv,
    input logic       ov,
    input logic       ov_en,
    input logic       stat_clr,
    input logic [7:0] status,
    input logic [7:0] unused_pad,
    input logic       out_off
);
    // R1
    clear_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (status == 8'h40));

    // R3
    hs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[4]) |-> $past(hs_oc));

    // R4
    hs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !stat_clr) |=> status[4]);

    // R4
    short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] || status[5]) |-> out_off);

    // R5
    ls_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[5]) |-> $past(ls_oc));

    // R6
    ol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> ($past(pwm) && $past(ol_low)));

    // R7
    temp_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_clr |=> (status[2:1] >= $past(status[2:1])));

    // R8
    temp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2:1] == 2'b11) |-> out_off);

    // R9
    uv_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv |=> out_off);

    // R10
    ov_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ov && !ov_en && !uv && !status[7]) |=> !status[7]);

    logic unused_ok;
    assign unused_ok = ^unused_pad;

endmodule

bind fault_diag_ctrl fdc_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hs_oc      (hs_oc),
    .ls_oc      (ls_oc),
    .ol_low     (ol_low),
    .pwm        (pwm),
    .uv         (uv),
    .ov         (ov),
    .ov_en      (ov_en),
    .stat_clr   (stat_clr),
    .status     (status),
    .unused_pad (8'h00),
    .out_off    (out_off)
);

// File: tb/sim_fault_diag_ctrl.sv
`timescale 1ns/1ps
module sim_fault_diag_ctrl;
    localparam int HSD = 25;
    localparam int BLK = 10;
    localparam int OLF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hs_oc = 0, ls_oc = 0, ol_low = 0, uv = 0, ov = 0, ov_en = 0;
    logic       pwm = 0, chop_evt = 0, stat_clr = 0;
    logic [1:0] temp_code = 2'b00;
    logic [7:0] status;
    logic       out_off;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fault_diag_ctrl #(.HS_DLY_CYC(HSD), .BLANK_CYC(BLK), .OL_FILT_CYC(OLF)) u0 (
        .clk(clk), .rst_n(rst_n), .hs_oc(hs_oc), .ls_oc(ls_oc), .ol_low(ol_low),
        .temp_code(temp_code), .uv(uv), .ov(ov), .ov_en(ov_en), .pwm(pwm),
        .chop_evt(chop_evt), .stat_clr(stat_clr), .status(status), .out_off(out_off)
    );

    // rows: {temp_code, stat_clr, expected status[2:1], expected out_off}
    localparam logic [5:0] TVEC [8] = '{
        6'b01_0_01_0, 6'b00_0_01_0, 6'b10_0_10_0, 6'b01_0_10_0,
        6'b00_1_00_0, 6'b11_0_11_1, 6'b00_0_11_1, 6'b00_1_00_0
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_pulse();
        stat_clr = 1'b1;
        tick();
        stat_clr = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 reset status", status, 8'h40);
        chk("R1 reset off", {7'd0, out_off}, 8'h00);

        // R7 R8 R2 temperature table
        for (int i = 0; i < 8; i++) begin
            temp_code = TVEC[i][5:4];
            stat_clr  = TVEC[i][3];
            tick();
            chk("R7 temp latch", {6'd0, status[2:1]}, {6'd0, TVEC[i][2:1]});
            chk("R8 temp off", {7'd0, out_off}, {7'd0, TVEC[i][0]});
            chk("R2 err flag", {7'd0, status[0]}, {7'd0, (TVEC[i][2:1] != 2'b00)});
        end
        temp_code = 2'b00;
        stat_clr  = 1'b0;

        // R3 high-side persistence
        hs_oc = 1'b1;
        repeat (HSD - 1) tick();
        chk("R3 one short", status, 8'h40);
        hs_oc = 1'b0;
        tick();
        hs_oc = 1'b1;
        repeat (HSD - 1) tick();
        chk("R3 restarted count", status, 8'h40);
        tick();
        chk("R3 latched", status, 8'h51);
        chk("R4 hs off", {7'd0, out_off}, 8'h01);
        hs_oc = 1'b0;
        repeat (5) tick();
        chk("R4 hs held", {status[7:1], out_off}, 8'h51);
        clear_pulse();
        chk("R1 clear status", status, 8'h40);
        chk("R1 clear off", {7'd0, out_off}, 8'h00);

        // R5 blanking window
        ls_oc = 1'b1;
        repeat (BLK + 2) tick();
        chk("R5 no window", status, 8'h40);
        ls_oc = 1'b0;
        chop_evt = 1'b1;
        tick();
        chop_evt = 1'b0;
        repeat (BLK) tick();
        ls_oc = 1'b1;
        tick();
        chk("R5 after window", status, 8'h40);
        chop_evt = 1'b1;
        tick();
        chop_evt = 1'b0;
        repeat (3) tick();
        chk("R5 second chop", {status[7:1], out_off}, 8'h40);
        ls_oc = 1'b0;
        clear_pulse();
        chop_evt = 1'b1;
        tick();
        chop_evt = 1'b0;
        repeat (BLK - 1) tick();
        ls_oc = 1'b1;
        tick();
        chk("R5 last window edge", status, 8'h61);
        chk("R4 ls off", {7'd0, out_off}, 8'h01);
        ls_oc = 1'b0;
        clear_pulse();
        chop_evt = 1'b1;
        tick();
        chop_evt = 1'b0;
        ls_oc = 1'b1;
        tick();
        chk("R11 rearmed window", status, 8'h61);
        ls_oc = 1'b0;
        clear_pulse();
        chk("R11 ls cleared", {status[7:1], out_off}, 8'h40);

        // R6 open load with pause
        pwm = 1'b1;
        ol_low = 1'b1;
        repeat (20) tick();
        pwm = 1'b0;
        repeat (30) tick();
        pwm = 1'b1;
        repeat (19) tick();
        chk("R6 one short", status, 8'h40);
        tick();
        chk("R6 latched", status, 8'h49);
        chk("R6 no off", {7'd0, out_off}, 8'h00);
        clear_pulse();
        repeat (OLF - 2) tick();
        ol_low = 1'b0;
        tick();
        ol_low = 1'b1;
        repeat (OLF - 1) tick();
        chk("R6 reset by current", status, 8'h40);
        tick();
        chk("R6 latched again", status, 8'h49);
        pwm = 1'b0;
        ol_low = 1'b0;
        clear_pulse();

        // R10 R9 supply
        ov = 1'b1;
        repeat (3) tick();
        chk("R10 ov masked", {status[7:1], out_off}, 8'h40);
        ov_en = 1'b1;
        tick();
        chk("R9 ov latched", status, 8'hC1);
        chk("R9 ov off", {7'd0, out_off}, 8'h01);
        ov = 1'b0;
        tick();
        chk("R9 auto restart", {status[7:1], out_off}, 8'hC0);
        clear_pulse();
        chk("R1 supply clear", status, 8'h40);
        uv = 1'b1;
        tick();
        chk("R9 uv latched", {status[7:1], out_off}, 8'hC1);
        clear_pulse();
        chk("R11 clear live", {status[7:1], out_off}, 8'h41);
        tick();
        chk("R11 relatched", status, 8'hC1);
        uv = 1'b0;
        tick();
        chk("R9 uv restart", {status[7:1], out_off}, 8'hC0);
        ov_en = 1'b0;
        clear_pulse();

        // R1 reset in the middle of a fault
        hs_oc = 1'b1;
        repeat (HSD + 1) tick();
        chk("R3 latched pre-reset", status, 8'h51);
        rst_n = 1'b0;
        hs_oc = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 mid reset", {status[7:1], out_off}, 8'h40);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule